// File: doc/BRIEF.md
# Congestion-Reactive Sender Rate Controller

This block sets the sending rate of a single flow. When a congestion notification packet (CNP) arrives, it lowers the flow's current rate by a fraction that depends on a running congestion estimate, alpha. Alpha moves toward 1.0 each time a CNP arrives and decays toward zero while the flow stays quiet.

While no CNPs arrive, the rate recovers toward a remembered target rate. Recovery passes through three stages in order: fast recovery, additive increase and hyper increase. Two independent trigger sources advance it: a transmitted-byte counter and a free-running increase timer. Every trigger event is one recovery step.

The rate pacer and the packet formats are outside this block. The block receives a CNP pulse, the byte count sent in each cycle and a set of configuration values. It returns the current rate and the recovery stage.

Top module: `rp_rate_ctrl`

The recovery stage is held in an enumerated register with three states:

- `STG_FAST` (code 0) moves to `STG_ADD` (code 1) on a step where either trigger kind has counted more than F events.
- `STG_ADD` moves to `STG_HYPER` (code 2) on a step where both kinds have counted more than F events.
- Every state returns to `STG_FAST` on a CNP.

## Requirements
- R1: While reset is held low at a clock edge, the rate output becomes `cfg_rate_init_i`, the stage becomes `STG_FAST` (0), alpha becomes 1024 (1.0) and all trigger accumulators and counts are cleared. Configuration must satisfy min ≤ init ≤ line.
- R2: A CNP sampled at an edge replaces the current rate Rc with max(min, Rc − floor(Rc·alpha/2048)) from that edge onward, using the alpha held before the edge. The target rate takes the old Rc.
- R3: Alpha is unsigned with a 10-bit fraction. On a CNP it becomes alpha − floor(alpha/2^G) + floor(1024/2^G), where G is `cfg_g_shift_i`. This new value takes effect after the cut of R2.
- R4: At each edge that completes `cfg_alpha_period_i` consecutive cycles without a CNP (counted from reset or from the last CNP), alpha becomes alpha − floor(alpha/2^G).
- R5: The byte trigger adds `tx_bytes_i` to an accumulator each cycle. When accumulator plus input reaches `cfg_byte_thresh_i` (which must be ≥1), it fires once and clears the accumulator; any excess is dropped.
- R6: The timer trigger fires at the edge completing every `cfg_timer_period_i` cycles (which must be ≥1), counted from reset or from the last CNP.
- R7: A trigger fired at edge E causes one recovery step at edge E+1. If neither kind has counted more than F=5 events, the step is fast recovery: Rc becomes floor((Rc+Rt)/2) and Rt is unchanged.
- R8: If exactly one kind has counted more than F events, the step is additive: Rt becomes min(line, Rt + `cfg_rate_ai_i`), then Rc becomes floor((Rc+Rt_new)/2). The stage output is 1.
- R9: If both kinds have counted more than F events, the step is hyper: Rt increases by `cfg_rate_hai_i`, capped at line, and Rc moves halfway toward the new Rt. The stage output is 2.
- R10: If both triggers fire at the same edge, exactly one recovery step is applied, but both event counts advance.
- R11: A CNP clears both accumulators, both event counts, any pending trigger and the alpha period. A CNP wins over a recovery step due in the same cycle, and the stage returns to 0.
- R12: The rate output always stays within [`cfg_rate_min_i`, `cfg_rate_line_i`].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnp_i | input | 1 | One-cycle pulse per received congestion notification |
| tx_bytes_i | input | TXB_W | Bytes sent by the flow this cycle |
| cfg_rate_init_i | input | RATE_W | Rate loaded at reset |
| cfg_rate_min_i | input | RATE_W | Lower rate bound |
| cfg_rate_line_i | input | RATE_W | Upper rate bound (line rate) |
| cfg_rate_ai_i | input | RATE_W | Target increment in additive stage |
| cfg_rate_hai_i | input | RATE_W | Target increment in hyper stage |
| cfg_byte_thresh_i | input | BYTE_ACC_W | Bytes per byte-trigger event |
| cfg_timer_period_i | input | TIMER_W | Cycles per timer-trigger event |
| cfg_alpha_period_i | input | APER_W | Cycles per alpha decay without CNP |
| cfg_g_shift_i | input | 4 | Alpha gain as a power-of-two shift |
| rate_o | output | RATE_W | Current rate |
| stage_o | output | 2 | Recovery stage: 0 fast, 1 additive, 2 hyper |

## Verification
A CNP sampled at an edge shows in `rate_o` and `stage_o` right after that same edge. A trigger crossing sampled at an edge shows up one edge later, because the fire flag is registered before the rate step. Alpha decay has no direct output and is observed through the size of the next cut. The bench drives inputs on falling edges and steps a cycle-accurate arithmetic model on each rising edge. It compares both outputs at every following falling edge, so each result is checked in exactly the cycle it is due. Configurations sweep gain, byte threshold, timer period and alpha period. Each run mixes random CNP traffic, long quiet stretches that reach the hyper stage, back-to-back CNPs, and byte-silent periods where only the timer advances.

// File: rtl/rp_rate_pkg.sv
package rp_rate_pkg;
    localparam int ALPHA_FRAC = 10;
    localparam int ALPHA_W    = ALPHA_FRAC + 1;

    typedef enum logic [1:0] {
        STG_FAST  = 2'd0,
        STG_ADD   = 2'd1,
        STG_HYPER = 2'd2
    } rp_stage_e;
endpackage

// File: rtl/rp_trig_gen.sv
// Accumulating trigger: fires once each time the running sum reaches the threshold.
module rp_trig_gen #(
    parameter int ACC_W   = 20,
    parameter int INC_W   = 16,
    parameter int CNT_W   = 3,
    parameter int CNT_MAX = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [INC_W-1:0] inc_i,
    input  logic [ACC_W-1:0] thresh_i,
    output logic             fire_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int SUM_W = ACC_W + 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;
    logic             hit;

    assign sum = {1'b0, acc_q} + SUM_W'(inc_i);
    assign hit = (sum >= {1'b0, thresh_i});

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc_q  <= '0;
            fire_o <= 1'b0;
            cnt_o  <= '0;
        end else if (hit) begin
            acc_q  <= '0;
            fire_o <= 1'b1;
            if (cnt_o != CNT_TOP) cnt_o <= cnt_o + 1'b1;
        end else begin
            acc_q  <= sum[ACC_W-1:0];
            fire_o <= 1'b0;
        end
    end

    // R11
    trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!fire_o && cnt_o == '0));

    // R5
    trig_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_TOP);

    // R5
    trig_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && hit && cnt_o != CNT_TOP) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/rp_alpha_est.sv
// Congestion estimate: rises toward 1.0 on CNP, decays by (1-g) per quiet period.
module rp_alpha_est
    import rp_rate_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnp_i,
    input  logic [PER_W-1:0]   period_i,
    input  logic [3:0]         gshift_i,
    output logic [ALPHA_W-1:0] alpha_o
);
    localparam logic [ALPHA_W-1:0] ALPHA_ONE = ALPHA_W'(1 << ALPHA_FRAC);

    logic [PER_W-1:0]   tick_q;
    logic [ALPHA_W-1:0] decayed;
    logic [ALPHA_W-1:0] raised;

    assign decayed = alpha_o - (alpha_o >> gshift_i);
    assign raised  = decayed + (ALPHA_ONE >> gshift_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alpha_o <= ALPHA_ONE;
            tick_q  <= '0;
        end else if (cnp_i) begin
            alpha_o <= raised;
            tick_q  <= '0;
        end else if (tick_q == period_i - 1'b1) begin
            alpha_o <= decayed;
            tick_q  <= '0;
        end else begin
            tick_q  <= tick_q + 1'b1;
        end
    end

    // R3
    alpha_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alpha_o <= ALPHA_ONE);

    // R3
    alpha_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnp_i |=> (alpha_o >= $past(alpha_o)));

    // R4
    alpha_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnp_i |=> (alpha_o <= $past(alpha_o)));
endmodule

// File: rtl/rp_rate_core.sv
// Stage state machine plus current/target rate registers.
module rp_rate_core
    import rp_rate_pkg::*;
#(
    parameter int RATE_W     = 16,
    parameter int CNT_W      = 3,
    parameter int FAST_STEPS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnp_i,
    input  logic               byte_fire_i,
    input  logic               time_fire_i,
    input  logic [CNT_W-1:0]   byte_cnt_i,
    input  logic [CNT_W-1:0]   time_cnt_i,
    input  logic [ALPHA_W-1:0] alpha_i,
    input  logic [RATE_W-1:0]  cfg_init_i,
    input  logic [RATE_W-1:0]  cfg_min_i,
    input  logic [RATE_W-1:0]  cfg_line_i,
    input  logic [RATE_W-1:0]  cfg_ai_i,
    input  logic [RATE_W-1:0]  cfg_hai_i,
    output logic [RATE_W-1:0]  rate_o,
    output rp_stage_e          stage_o
);
    localparam int PROD_W = RATE_W + ALPHA_W;
    localparam int SUM_W  = RATE_W + 1;
    localparam int CUT_SH = ALPHA_FRAC + 1;
    localparam logic [CNT_W-1:0] F_LIM = CNT_W'(FAST_STEPS);

    rp_stage_e         stage_q;
    rp_stage_e         stage_nxt;
    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] tgt_q;
    logic              step;
    logic              byte_past;
    logic              time_past;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] cut;
    logic [RATE_W-1:0] rc_cut_raw;
    logic [RATE_W-1:0] rc_cut;
    logic [SUM_W-1:0]  tgt_sum;
    logic [RATE_W-1:0] tgt_inc;
    logic [SUM_W-1:0]  mid;
    logic [RATE_W-1:0] rc_inc;

    assign step      = byte_fire_i | time_fire_i;
    assign byte_past = (byte_cnt_i > F_LIM);
    assign time_past = (time_cnt_i > F_LIM);

    // Next stage from the event counts that include the firing event.
    always_comb begin
        unique case ({byte_past, time_past})
            2'b11:        stage_nxt = STG_HYPER;
            2'b10, 2'b01: stage_nxt = STG_ADD;
            default:      stage_nxt = STG_FAST;
        endcase
    end

    // Multiplicative cut.
    always_comb begin
        prod       = PROD_W'(rate_q) * PROD_W'(alpha_i);
        cut        = prod >> CUT_SH;
        rc_cut_raw = rate_q - cut[RATE_W-1:0];
        rc_cut     = (rc_cut_raw < cfg_min_i) ? cfg_min_i : rc_cut_raw;
    end

    // Recovery step.
    always_comb begin
        tgt_sum = {1'b0, tgt_q};
        unique case (stage_nxt)
            STG_ADD:   tgt_sum = {1'b0, tgt_q} + {1'b0, cfg_ai_i};
            STG_HYPER: tgt_sum = {1'b0, tgt_q} + {1'b0, cfg_hai_i};
            default:   tgt_sum = {1'b0, tgt_q};
        endcase
        tgt_inc = (tgt_sum > {1'b0, cfg_line_i}) ? cfg_line_i : tgt_sum[RATE_W-1:0];
        mid     = ({1'b0, rate_q} + {1'b0, tgt_inc}) >> 1;
        if (mid[RATE_W-1:0] < cfg_min_i)       rc_inc = cfg_min_i;
        else if (mid[RATE_W-1:0] > cfg_line_i) rc_inc = cfg_line_i;
        else                                   rc_inc = mid[RATE_W-1:0];
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)     stage_q <= STG_FAST;
        else if (cnp_i) stage_q <= STG_FAST;
        else if (step)  stage_q <= stage_nxt;
    end

    // Rate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= cfg_init_i;
            tgt_q  <= cfg_init_i;
        end else if (cnp_i) begin
            rate_q <= rc_cut;
            tgt_q  <= rate_q;
        end else if (step) begin
            rate_q <= rc_inc;
            tgt_q  <= tgt_inc;
        end
    end

    assign rate_o  = rate_q;
    assign stage_o = stage_q;

    // R2
    cut_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnp_i |=> (rate_q <= $past(rate_q)));

    // R2
    cut_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnp_i |=> (tgt_q == $past(rate_q)));

    // R7
    fast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnp_i && step && stage_nxt == STG_FAST) |=> $stable(tgt_q));

    // R8
    tgt_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnp_i && step) |=> (tgt_q >= $past(tgt_q)));

    // R11
    cnp_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnp_i |=> (stage_q == STG_FAST));

    // R12
    rate_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_min_i <= cfg_line_i) |-> (rate_q >= cfg_min_i && rate_q <= cfg_line_i));
endmodule

// File: rtl/rp_rate_ctrl.sv
module rp_rate_ctrl
    import rp_rate_pkg::*;
#(
    parameter int RATE_W     = 16,
    parameter int TXB_W      = 16,
    parameter int BYTE_ACC_W = 20,
    parameter int TIMER_W    = 16,
    parameter int APER_W     = 16,
    parameter int FAST_STEPS = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cnp_i,
    input  logic [TXB_W-1:0]      tx_bytes_i,
    input  logic [RATE_W-1:0]     cfg_rate_init_i,
    input  logic [RATE_W-1:0]     cfg_rate_min_i,
    input  logic [RATE_W-1:0]     cfg_rate_line_i,
    input  logic [RATE_W-1:0]     cfg_rate_ai_i,
    input  logic [RATE_W-1:0]     cfg_rate_hai_i,
    input  logic [BYTE_ACC_W-1:0] cfg_byte_thresh_i,
    input  logic [TIMER_W-1:0]    cfg_timer_period_i,
    input  logic [APER_W-1:0]     cfg_alpha_period_i,
    input  logic [3:0]            cfg_g_shift_i,
    output logic [RATE_W-1:0]     rate_o,
    output logic [1:0]            stage_o
);
    localparam int CNT_MAX = FAST_STEPS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic               byte_fire;
    logic               time_fire;
    logic [CNT_W-1:0]   byte_cnt;
    logic [CNT_W-1:0]   time_cnt;
    logic [ALPHA_W-1:0] alpha;
    rp_stage_e          stage;

    rp_trig_gen #(
        .ACC_W  (BYTE_ACC_W),
        .INC_W  (TXB_W),
        .CNT_W  (CNT_W),
        .CNT_MAX(CNT_MAX)
    ) i_byte_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnp_i),
        .inc_i   (tx_bytes_i),
        .thresh_i(cfg_byte_thresh_i),
        .fire_o  (byte_fire),
        .cnt_o   (byte_cnt)
    );

    rp_trig_gen #(
        .ACC_W  (TIMER_W),
        .INC_W  (1),
        .CNT_W  (CNT_W),
        .CNT_MAX(CNT_MAX)
    ) i_time_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnp_i),
        .inc_i   (1'b1),
        .thresh_i(cfg_timer_period_i),
        .fire_o  (time_fire),
        .cnt_o   (time_cnt)
    );

    rp_alpha_est #(
        .PER_W(APER_W)
    ) i_alpha (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnp_i   (cnp_i),
        .period_i(cfg_alpha_period_i),
        .gshift_i(cfg_g_shift_i),
        .alpha_o (alpha)
    );

    rp_rate_core #(
        .RATE_W    (RATE_W),
        .CNT_W     (CNT_W),
        .FAST_STEPS(FAST_STEPS)
    ) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnp_i      (cnp_i),
        .byte_fire_i(byte_fire),
        .time_fire_i(time_fire),
        .byte_cnt_i (byte_cnt),
        .time_cnt_i (time_cnt),
        .alpha_i    (alpha),
        .cfg_init_i (cfg_rate_init_i),
        .cfg_min_i  (cfg_rate_min_i),
        .cfg_line_i (cfg_rate_line_i),
        .cfg_ai_i   (cfg_rate_ai_i),
        .cfg_hai_i  (cfg_rate_hai_i),
        .rate_o     (rate_o),
        .stage_o    (stage)
    );

    assign stage_o = stage;
endmodule

// File: tb/test_rp_rate_ctrl.sv
`timescale 1ns/1ps
module test_rp_rate_ctrl;
    localparam int F = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnp = 1'b0;
    logic [15:0] tx = '0;
    logic [15:0] c_init = 16'd40000;
    logic [15:0] c_min  = 16'd1000;
    logic [15:0] c_line = 16'd50000;
    logic [15:0] c_ai   = 16'd500;
    logic [15:0] c_hai  = 16'd3000;
    logic [19:0] c_bth  = 20'd64;
    logic [15:0] c_tper = 16'd7;
    logic [15:0] c_aper = 16'd5;
    logic [3:0]  c_g    = 4'd1;
    logic [15:0] rate_o;
    logic [1:0]  stage_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rp_rate_ctrl i_rp_rate_ctrl (
        .clk               (clk),
        .rst_n             (rst_n),
        .cnp_i             (cnp),
        .tx_bytes_i        (tx),
        .cfg_rate_init_i   (c_init),
        .cfg_rate_min_i    (c_min),
        .cfg_rate_line_i   (c_line),
        .cfg_rate_ai_i     (c_ai),
        .cfg_rate_hai_i    (c_hai),
        .cfg_byte_thresh_i (c_bth),
        .cfg_timer_period_i(c_tper),
        .cfg_alpha_period_i(c_aper),
        .cfg_g_shift_i     (c_g),
        .rate_o            (rate_o),
        .stage_o           (stage_o)
    );

    // Arithmetic reference, stepped on each rising edge from the requirements.
    int m_rc, m_rt, m_al, m_bacc, m_tacc, m_bc, m_tc, m_acnt, m_st;
    bit m_bp, m_tp;
    string m_tag = "R1";

    always @(posedge clk) begin
        int nrc, nrt, s, g;
        g = int'(c_g);
        if (!rst_n) begin
            m_rc = int'(c_init); m_rt = int'(c_init); m_al = 1024;
            m_bacc = 0; m_tacc = 0; m_bc = 0; m_tc = 0; m_acnt = 0;
            m_bp = 0; m_tp = 0; m_st = 0; m_tag = "R1";
        end else if (cnp) begin
            nrt = m_rc;
            nrc = m_rc - ((m_rc * m_al) >>> 11);
            if (nrc < int'(c_min)) nrc = int'(c_min);
            m_rc = nrc; m_rt = nrt;
            m_al = m_al - (m_al >>> g) + (1024 >>> g);
            m_bacc = 0; m_tacc = 0; m_bc = 0; m_tc = 0; m_acnt = 0;
            m_bp = 0; m_tp = 0; m_st = 0;
            m_tag = "R2 R3 R4 R11 R12";
        end else begin
            if (m_bp || m_tp) begin
                s = (m_bc > F && m_tc > F) ? 2 : ((m_bc > F || m_tc > F) ? 1 : 0);
                if (s == 0)      nrt = m_rt;
                else if (s == 1) nrt = m_rt + int'(c_ai);
                else             nrt = m_rt + int'(c_hai);
                if (nrt > int'(c_line)) nrt = int'(c_line);
                nrc = (m_rc + nrt) >>> 1;
                if (nrc < int'(c_min)) nrc = int'(c_min);
                if (nrc > int'(c_line)) nrc = int'(c_line);
                m_rc = nrc; m_rt = nrt; m_st = s;
                m_tag = (s == 0) ? "R7" : ((s == 1) ? "R8" : "R9");
                if (m_bp) m_tag = {m_tag, " R5"};
                if (m_tp) m_tag = {m_tag, " R6"};
                if (m_bp && m_tp) m_tag = {m_tag, " R10"};
            end else begin
                m_tag = "R12 hold";
            end
            if (m_acnt == int'(c_aper) - 1) begin
                m_acnt = 0; m_al = m_al - (m_al >>> g);
            end else m_acnt++;
            if (m_bacc + int'(tx) >= int'(c_bth)) begin
                m_bacc = 0; m_bp = 1; if (m_bc < F + 1) m_bc++;
            end else begin
                m_bacc = m_bacc + int'(tx); m_bp = 0;
            end
            if (m_tacc + 1 >= int'(c_tper)) begin
                m_tacc = 0; m_tp = 1; if (m_tc < F + 1) m_tc++;
            end else begin
                m_tacc = m_tacc + 1; m_tp = 0;
            end
        end
    end

    task automatic cmp();
        n_cmp++;
        if (rate_o !== 16'(m_rc)) begin
            n_bad++;
            $display("FAIL %s rate got %0d exp %0d at %0t", m_tag, rate_o, m_rc, $time);
        end
        n_cmp++;
        if (stage_o !== 2'(m_st)) begin
            n_bad++;
            $display("FAIL %s stage got %0d exp %0d at %0t", m_tag, stage_o, m_st, $time);
        end
    endtask

    task automatic cyc(input logic c, input int t);
        @(negedge clk);
        cmp();
        cnp = c;
        tx  = 16'(t);
    endtask

    task automatic do_reset();
        @(negedge clk);
        cnp = 1'b0; tx = '0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        cmp();  // R1: reset values
        rst_n = 1'b1;
    endtask

    initial begin
        for (int gi = 1; gi <= 3; gi++) begin
            for (int bi = 0; bi < 2; bi++) begin
                for (int ti = 0; ti < 2; ti++) begin
                    for (int ai = 0; ai < 2; ai++) begin
                        c_g    = 4'(gi);
                        c_bth  = (bi == 0) ? 20'd64 : 20'd200;
                        c_tper = (ti == 0) ? 16'd7 : 16'd13;
                        c_aper = (ai == 0) ? 16'd5 : 16'd11;
                        do_reset();
                        // Random CNP traffic (R2, R3, R4)
                        for (int k = 0; k < 150; k++)
                            cyc(($urandom % 12) == 0, int'($urandom % 64));
                        // Long quiet stretch reaching hyper (R5, R7, R8, R9, R10)
                        for (int k = 0; k < 350; k++)
                            cyc(1'b0, int'($urandom % 64));
                        // Back-to-back CNPs (R11, R12)
                        for (int k = 0; k < 3; k++) cyc(1'b1, 40);
                        // Timer only, no bytes (R6, R8)
                        for (int k = 0; k < 120; k++) cyc(1'b0, 0);
                        // Single CNP then heavy bytes
                        cyc(1'b1, 63);
                        for (int k = 0; k < 40; k++) cyc(1'b0, 63);
                    end
                end
            end
        end
        @(negedge clk);
        cmp();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired: got running exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule